// File: doc/BRIEF.md
# Fifteen-Bit Packet Error Code Engine

This block computes the 15-bit cyclic code that guards each command word and each data group on a chained serial monitoring link. Bytes arrive one per clock with a valid strobe and are folded into a 15-bit remainder most significant bit first, with all eight bit-steps of a byte resolved in the same cycle. A start pulse puts the remainder back to its fixed non-zero seed, so one instance can be reused for the command word and then for each device's data group in turn.

The code is presented as two bytes: the 15-bit remainder shifted up by one place with a zero in the lowest bit, high byte first. In the receive direction the same engine compares two incoming code bytes with the value it has computed over the preceding payload and raises a one-cycle error flag when they disagree. Framing of the serial link lies outside this block.

Top module: `pec15_engine`

## Requirements
- R1: After reset the code output `pec_o` equals the seed code 0x0020 (remainder seed 0x0010 shifted left by one).
- R2: A `start_i` pulse without `byte_vld_i` sets `pec_o` to 0x0020 at the next clock edge.
- R3: For each data bit, taken most significant first, the feedback term is the data bit XOR remainder bit 14; bit 0 takes the feedback, bits 3, 4, 7, 8, 10 and 14 take the lower neighbour XOR feedback, and the other bits take the lower neighbour. The payload 0x00, 0x01 from the seed gives `pec_o` = 0x3D6E.
- R4: One byte is absorbed on every clock edge where `byte_vld_i` is high, so back-to-back bytes give the same code as bytes separated by idle cycles.
- R5: When `start_i` and `byte_vld_i` are high in the same cycle, the byte is folded into the seed, not into the old remainder.
- R6: In a cycle with neither `start_i` nor `byte_vld_i`, `pec_o` does not change.
- R7: Bit 0 of `pec_o` is always 0; `pec_o[15:8]` is the byte sent first.
- R8: The first `rx_vld_i` byte after a start is compared with `pec_o[15:8]`, the second with `pec_o[7:0]`; one cycle after the second, `chk_done_o` pulses high for one cycle and `chk_err_o` is high in that same cycle only if either byte differed.
- R9: A mismatch in only the high byte or only the low byte each sets `chk_err_o`.
- R10: A `start_i` pulse between the two received code bytes abandons the comparison: no `chk_done_o` follows the next single byte.
- R11: Received code bytes do not change `pec_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Reload seed, restart comparison phase |
| byte_vld_i | input | 1 | Payload byte strobe |
| byte_i | input | 8 | Payload byte |
| rx_vld_i | input | 1 | Received code byte strobe |
| rx_byte_i | input | 8 | Received code byte, high byte first |
| pec_o | output | 16 | Code: remainder shifted left, LSB zero |
| chk_done_o | output | 1 | Comparison finished (one-cycle pulse) |
| chk_err_o | output | 1 | Comparison found a mismatch (with done) |

## Verification
The bench aims at the seed handling: a start coinciding with a byte, which a design that stepped the stale remainder would fold into the wrong base, and a bare start after a long payload, which a design without reload would leave unchanged. A fixed known payload catches a wrong tap or a missing bit-0 feedback, which would give a different code than 0x3D6E. On the receive side, errors placed only in the high byte or only in the low byte catch a comparator that checks just one half, and a start between the two code bytes catches a phase counter that is not cleared and would report a stale completion.

// File: rtl/pec15_pkg.sv
package pec15_pkg;
  // remainder width and byte width of the link
  localparam int CRC_W  = 15;
  localparam int BYTE_W = 8;
  localparam int CODE_W = CRC_W + 1;
  // generator taps (x^15 implied), bit 0 is the feedback itself
  localparam logic [CRC_W-1:0] POLY = 15'h4599;
  // starting remainder for every protected group
  localparam logic [CRC_W-1:0] SEED = 15'h0010;
endpackage

// File: rtl/pec15_byte_step.sv
// Folds one byte into the remainder, all bit-steps unrolled.
module pec15_byte_step #(
  parameter int                CRC_W  = pec15_pkg::CRC_W,
  parameter int                BYTE_W = pec15_pkg::BYTE_W,
  parameter logic [CRC_W-1:0]  POLY   = pec15_pkg::POLY
) (
  input  logic [CRC_W-1:0]  rem_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  rem_o
);
  logic [CRC_W-1:0] stage [BYTE_W+1];

  assign stage[0] = rem_i;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
    logic fb;
    assign fb = data_i[BYTE_W-1-g] ^ stage[g][CRC_W-1];
    assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
  end

  assign rem_o = stage[BYTE_W];
endmodule

// File: rtl/pec15_rem_reg.sv
// Remainder state: seed reload, byte update, hold.
module pec15_rem_reg #(
  parameter int               CRC_W = pec15_pkg::CRC_W,
  parameter logic [CRC_W-1:0] SEED  = pec15_pkg::SEED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_vld_i,
  input  logic [CRC_W-1:0] stepped_i,
  output logic [CRC_W-1:0] base_o,
  output logic [CRC_W-1:0] rem_o
);
  logic [CRC_W-1:0] rem_q;
  logic [CRC_W-1:0] rem_d;
  logic             rem_en;

  // base the byte is folded into: seed when a start coincides
  always_comb begin
    base_o = start_i ? SEED : rem_q;
  end

  always_comb begin
    rem_en = start_i | byte_vld_i;
    rem_d  = byte_vld_i ? stepped_i : SEED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= SEED;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign rem_o = rem_q;
endmodule

// File: rtl/pec15_rx_check.sv
// Compares two received code bytes with the computed code.
module pec15_rx_check #(
  parameter int CODE_W = pec15_pkg::CODE_W,
  parameter int BYTE_W = pec15_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rx_vld_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              done_o,
  output logic              err_o
);
  logic phase_q, phase_d;
  logic hi_bad_q, hi_bad_d;
  logic done_q, done_d;
  logic err_q, err_d;
  logic lo_bad;

  assign lo_bad = (rx_byte_i != code_i[BYTE_W-1:0]);

  always_comb begin
    phase_d  = phase_q;
    hi_bad_d = hi_bad_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    if (start_i) begin
      phase_d  = 1'b0;
      hi_bad_d = 1'b0;
    end else if (rx_vld_i) begin
      if (!phase_q) begin
        phase_d  = 1'b1;
        hi_bad_d = (rx_byte_i != code_i[CODE_W-1:CODE_W-BYTE_W]);
      end else begin
        phase_d  = 1'b0;
        hi_bad_d = 1'b0;
        done_d   = 1'b1;
        err_d    = hi_bad_q | lo_bad;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      hi_bad_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      hi_bad_q <= hi_bad_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pec15_engine.sv
// Top: remainder state, unrolled byte step, received-code comparator.
module pec15_engine #(
  parameter int                           CRC_W  = pec15_pkg::CRC_W,
  parameter int                           BYTE_W = pec15_pkg::BYTE_W,
  parameter logic [CRC_W-1:0]             POLY   = pec15_pkg::POLY,
  parameter logic [CRC_W-1:0]             SEED   = pec15_pkg::SEED,
  localparam int                          CODE_W = CRC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rx_vld_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic [CODE_W-1:0] pec_o,
  output logic              chk_done_o,
  output logic              chk_err_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] stepped;
  logic [CRC_W-1:0] rem;

  pec15_rem_reg #(.CRC_W(CRC_W), .SEED(SEED)) u_rem (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .stepped_i  (stepped),
    .base_o     (base),
    .rem_o      (rem)
  );

  pec15_byte_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY)) u_step (
    .rem_i  (base),
    .data_i (byte_i),
    .rem_o  (stepped)
  );

  assign pec_o = {rem, 1'b0};

  pec15_rx_check #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start_i   (start_i),
    .rx_vld_i  (rx_vld_i),
    .rx_byte_i (rx_byte_i),
    .code_i    (pec_o),
    .done_o    (chk_done_o),
    .err_o     (chk_err_o)
  );
endmodule

// File: rtl/pec15_engine_chk.sv
module pec15_engine_chk #(
  parameter int    CODE_W = 16,
  parameter int    BYTE_W = 8,
  parameter logic [CODE_W-1:0] SEED_CODE = 16'h0020
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              byte_vld_i,
  input logic              rx_vld_i,
  input logic [BYTE_W-1:0] rx_byte_i,
  input logic [CODE_W-1:0] pec_o,
  input logic              chk_done_o,
  input logic              chk_err_o
);
  logic unused_rx;
  assign unused_rx = ^rx_byte_i;

  assert_lsb_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pec_o[0] == 1'b0);

  assert_start_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !byte_vld_i) |=> (pec_o == SEED_CODE));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !byte_vld_i) |=> $stable(pec_o));

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err_o |-> chk_done_o);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done_o |=> !chk_done_o);

  assert_rx_no_touch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld_i && !start_i && !byte_vld_i && !unused_rx) |=> $stable(pec_o));
endmodule

bind pec15_engine pec15_engine_chk #(
  .CODE_W    (CODE_W),
  .BYTE_W    (BYTE_W),
  .SEED_CODE ({SEED, 1'b0})
) u_pec15_engine_chk (
  .clk        (clk),
  .rst_n      (rst_sync_q),
  .start_i    (start_i),
  .byte_vld_i (byte_vld_i),
  .rx_vld_i   (rx_vld_i),
  .rx_byte_i  (rx_byte_i),
  .pec_o      (pec_o),
  .chk_done_o (chk_done_o),
  .chk_err_o  (chk_err_o)
);

// File: tb/tb_pec15_engine.sv
`timescale 1ns/1ps
module tb_pec15_engine;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        byte_vld_i;
  logic [7:0]  byte_i;
  logic        rx_vld_i;
  logic [7:0]  rx_byte_i;
  logic [15:0] pec_o;
  logic        chk_done_o;
  logic        chk_err_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  pec15_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .rx_vld_i(rx_vld_i), .rx_byte_i(rx_byte_i),
    .pec_o(pec_o), .chk_done_o(chk_done_o), .chk_err_o(chk_err_o)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // reference model written from the bit rule of R3
  function automatic logic [14:0] model_byte(input logic [14:0] r, input logic [7:0] b);
    logic [14:0] x;
    logic        fb;
    x = r;
    for (int i = 7; i >= 0; i--) begin
      fb = b[i] ^ x[14];
      x  = {x[13:0], 1'b0} ^ (fb ? 15'h4599 : 15'h0000);
    end
    return x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic send_bytes(input logic [7:0] b [], input bit gaps);
    foreach (b[i]) begin
      @(negedge clk); byte_vld_i = 1; byte_i = b[i];
      if (gaps) begin @(negedge clk); byte_vld_i = 0; end
    end
    @(negedge clk); byte_vld_i = 0;
  endtask

  task automatic send_rx(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk); rx_vld_i = 1; rx_byte_i = hi;
    @(negedge clk); rx_byte_i = lo;
    @(negedge clk); rx_vld_i = 0;
  endtask

  task automatic t_reset();
    check("R1 reset code", pec_o, 16'h0020);
    check("R1 reset done", chk_done_o, 0);
  endtask

  task automatic t_known();
    pulse_start();
    send_bytes('{8'h00, 8'h01}, 0);
    check("R3 known vector", pec_o, 16'h3D6E);
    check("R7 lsb zero", pec_o[0], 0);
  endtask

  task automatic t_patterns();
    logic [7:0]  pats [3][6] = '{'{8'hFF,8'h00,8'hA5,8'h5A,8'h12,8'h80},
                                 '{8'h01,8'h02,8'h04,8'h08,8'h10,8'h20},
                                 '{8'hDE,8'hAD,8'hBE,8'hEF,8'hC3,8'h3C}};
    for (int p = 0; p < 3; p++) begin
      logic [14:0] m;
      logic [15:0] back;
      m = 15'h0010;
      for (int i = 0; i < 6; i++) m = model_byte(m, pats[p][i]);
      pulse_start();
      send_bytes(pats[p], 0);
      back = pec_o;
      check("R4 back-to-back group", pec_o, {m, 1'b0});
      pulse_start();
      send_bytes(pats[p], 1);
      check("R4 gapped equals back-to-back", pec_o, back);
    end
  endtask

  task automatic t_start_with_byte();
    pulse_start();
    send_bytes('{8'h77, 8'h99, 8'h31}, 0);
    @(negedge clk); start_i = 1; byte_vld_i = 1; byte_i = 8'h00;
    @(negedge clk); start_i = 0; byte_i = 8'h01;
    @(negedge clk); byte_vld_i = 0;
    check("R5 start with byte uses seed", pec_o, 16'h3D6E);
  endtask

  task automatic t_reload_and_hold();
    logic [15:0] keep;
    pulse_start();
    send_bytes('{8'h11, 8'h22, 8'h33, 8'h44}, 0);
    keep = pec_o;
    byte_i = 8'hAB;
    idle(5);
    check("R6 idle hold", pec_o, keep);
    pulse_start();
    check("R2 start reloads seed", pec_o, 16'h0020);
  endtask

  task automatic t_rx(input logic [7:0] xh, input logic [7:0] xl, input bit exp_err, input string req);
    logic [14:0] m;
    logic [15:0] c;
    m = model_byte(model_byte(model_byte(15'h0010, 8'h3A), 8'h9C), 8'h05);
    c = {m, 1'b0};
    pulse_start();
    send_bytes('{8'h3A, 8'h9C, 8'h05}, 0);
    @(negedge clk); rx_vld_i = 1; rx_byte_i = c[15:8] ^ xh;
    @(negedge clk); rx_byte_i = c[7:0] ^ xl;
    @(negedge clk); rx_vld_i = 0;
    check({req, " done"}, chk_done_o, 1);
    check({req, " err"}, chk_err_o, exp_err);
    check("R11 rx leaves code", pec_o, c);
    @(negedge clk);
    check("R8 done one cycle", chk_done_o, 0);
  endtask

  task automatic t_abandon();
    pulse_start();
    send_bytes('{8'h00, 8'h01}, 0);
    @(negedge clk); rx_vld_i = 1; rx_byte_i = 8'h3D;
    @(negedge clk); rx_vld_i = 0; start_i = 1;
    @(negedge clk); start_i = 0;
    send_rx(8'h00, 8'h20);
    // after the restart a fresh pair is the first pair: seed code matches
    check("R10 fresh pair after start", chk_err_o, 0);
    pulse_start();
    @(negedge clk); rx_vld_i = 1; rx_byte_i = 8'h00;
    @(negedge clk); rx_vld_i = 0; start_i = 1;
    @(negedge clk); start_i = 0; rx_vld_i = 1; rx_byte_i = 8'h20;
    @(negedge clk); rx_vld_i = 0;
    check("R10 no done after abandoned pair", chk_done_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=hang expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; byte_vld_i = 0; byte_i = 0;
    rx_vld_i = 0; rx_byte_i = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    t_reset();
    t_known();
    t_patterns();
    t_start_with_byte();
    t_reload_and_hold();
    t_rx(8'h00, 8'h00, 0, "R8 match");
    t_rx(8'h40, 8'h00, 1, "R9 high byte mismatch");
    t_rx(8'h00, 8'h02, 1, "R9 low byte mismatch");
    t_abandon();
    finished = 1;
    summary();
    $finish;
  end
endmodule